// File: doc/BRIEF.md
# Register-Mapped SPI Word Master

This block lets a host processor run an SPI bus one word at a time through a handful of word-addressed registers. Writing a word to the transmit register queues it in a one-word holding slot; the shift engine takes it from there, clocks it out most significant bit first in mode 0 (serial clock idles low, data sampled on the rising edge), and captures the word returned by the selected target. The host then reads the captured word, right-aligned and zero-extended to 32 bits, from the receive register.

Hardware sets the status flags; the host clears them. Reading the receive register drops the data-ready flag, and any write to the status register drops both error flags. An interrupt line combines each flag with its own enable bit in the control register. The chip-select lines are active low and follow a one-hot target mask: the selected line is asserted while a word is pending or shifting, and a force bit in the control register keeps it asserted between words until the host clears the bit.

Register word addresses (byte offset divided by four): receive data 0, transmit data 1, status 2, control 3, target select 5.

Top module: `spi_word_master`

## Requirements
- R1: After reset, status reads 0x060 (transmit-ready and shifter-empty set, all else clear), receive data reads 0, every ss_n line is high, sclk is low and irq is low.
- R2: A transmit write sends the low DATA_W bits MSB first with sclk idling low and mosi stable across each rising sclk edge; miso is sampled on rising edges and the word is readable right-aligned at receive data.
- R3: Status bit 7 (data ready) sets when a word completes and clears when the receive-data register is read.
- R4: Status bit 6 (transmit ready) is high exactly when the holding slot is empty, so a second word written while the first shifts is accepted and sent after it; status bit 5 (empty) is high only when both the holding slot and the shifter are idle.
- R5: A transmit write while bit 6 is low sets status bit 4 (transmit overrun) and the word is dropped: it never appears on mosi.
- R6: A word completing while bit 7 is still set and the receive register is not read in that cycle sets status bit 3 (receive overrun) and replaces the stored word; a read in the completing cycle returns the old word and sets no overrun.
- R7: Status bit 8 equals bit 3 OR bit 4, and any write to the status register clears bits 3 and 4.
- R8: Control bits 3, 4, 6, 7 and 8 enable the interrupt for status bits 3, 4, 6, 7 and 8; irq is the OR of each status bit ANDed with its enable. Control reads back only bits 3, 4, 6, 7, 8 and 10.
- R9: ss_n[n] is low during a pending or shifting word only if target-select bit n is 1; a target-select value of 0 keeps all lines high.
- R10: Control bit 10 holds the selected ss_n lines low while idle and between words until it is cleared.
- R11: Each sclk high and low phase lasts CLK_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on receive data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the address |
| irq | output | 1 | Interrupt request, active high |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to targets |
| miso | input | 1 | SPI data from targets |
| ss_n | output | NUM_TGT | Active-low chip selects, one per target |

## Verification
The delicate coincidence is the host reading the receive register in the very cycle a new word lands in it: the read clear of the data-ready flag and the hardware set, plus the overrun decision, all resolve on one edge. The bench leaves one word unread, sends a second, counts falling sclk edges until the last one, and drives the read strobe into the next clock so it meets the completion pulse exactly. It then expects the old word on the bus, data ready still set, no overrun, and the new word on the following read; a separate run without the read must raise the overrun flag.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // register word addresses
    localparam logic [2:0] ADR_RX   = 3'd0;
    localparam logic [2:0] ADR_TX   = 3'd1;
    localparam logic [2:0] ADR_STAT = 3'd2;
    localparam logic [2:0] ADR_CTRL = 3'd3;
    localparam logic [2:0] ADR_SEL  = 3'd5;

    // status and control bit positions
    localparam int B_ROE   = 3;
    localparam int B_TOE   = 4;
    localparam int B_TMT   = 5;
    localparam int B_TRDY  = 6;
    localparam int B_RRDY  = 7;
    localparam int B_ERR   = 8;
    localparam int B_FORCE = 10;

    localparam int CTRL_W = 11;
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 11'b101_1101_1000;

    typedef struct packed {
        logic rrdy;
        logic roe;
        logic toe;
    } flags_t;

endpackage

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] word,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              done;
        logic [CNT_W-1:0]  div;
        logic [BIT_W-1:0]  bits;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.busy) begin
            if (start) begin
                sh_d.busy = 1'b1;
                sh_d.tx   = word;
                sh_d.div  = '0;
                sh_d.bits = '0;
                sh_d.sclk = 1'b0;
            end
        end else if (sh_q.div == DIV_LAST) begin
            sh_d.div  = '0;
            sh_d.sclk = !sh_q.sclk;
            if (!sh_q.sclk) begin
                // rising edge: sample the target
                sh_d.rx = {sh_q.rx[DATA_W-2:0], miso};
            end else begin
                // falling edge: present the next bit
                sh_d.tx = {sh_q.tx[DATA_W-2:0], 1'b0};
                if (sh_q.bits == BIT_LAST) begin
                    sh_d.busy = 1'b0;
                    sh_d.done = 1'b1;
                end else begin
                    sh_d.bits = sh_q.bits + 1'b1;
                end
            end
        end else begin
            sh_d.div = sh_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign busy    = sh_q.busy;
    assign sclk    = sh_q.sclk;
    assign mosi    = sh_q.tx[DATA_W-1];
    assign done    = sh_q.done;
    assign rx_word = sh_q.rx;

    // R2: data may only move on falling edges
    a_r2_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
    // R2: mode 0 idle level
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

endmodule

// File: rtl/spim_flags.sv
module spim_flags
    import spim_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rx_done,
    input  logic   rx_read,
    input  logic   stat_wr,
    input  logic   tx_reject,
    output flags_t flags
);
    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (rx_done)      fl_d.rrdy = 1'b1;
        else if (rx_read) fl_d.rrdy = 1'b0;

        if (rx_done && fl_q.rrdy && !rx_read) fl_d.roe = 1'b1;
        else if (stat_wr)                     fl_d.roe = 1'b0;

        if (tx_reject)    fl_d.toe = 1'b1;
        else if (stat_wr) fl_d.toe = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q;

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && !rx_done) |=> !flags.rrdy);
    a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && flags.rrdy && !rx_read) |=> flags.roe);
    a_r5_reject_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reject |=> flags.toe);
    a_r7_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !tx_reject && !rx_done) |=> (!flags.roe && !flags.toe));

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spim_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_TGT = 4,
    parameter int CLK_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_TGT-1:0] ss_n
);
    typedef struct packed {
        logic               hold_v;
        logic [DATA_W-1:0]  hold;
        logic [DATA_W-1:0]  rxd;
        logic [CTRL_W-1:0]  ctrl;
        logic [NUM_TGT-1:0] sel;
    } rf_t;

    rf_t rf_d, rf_q;

    logic              sh_busy, sh_done, sh_start;
    logic [DATA_W-1:0] sh_rx;
    logic              wr_tx, wr_stat, rd_rx, tx_reject;
    logic              trdy, tmt, ss_active;
    logic [31:0]       status;
    flags_t            flags;

    assign wr_tx     = bus_wr && (bus_addr == ADR_TX);
    assign wr_stat   = bus_wr && (bus_addr == ADR_STAT);
    assign rd_rx     = bus_rd && (bus_addr == ADR_RX);
    assign tx_reject = wr_tx && rf_q.hold_v;
    assign sh_start  = rf_q.hold_v && !sh_busy;

    always_comb begin
        rf_d = rf_q;
        if (sh_start)                    rf_d.hold_v = 1'b0;
        if (wr_tx && !rf_q.hold_v) begin
            rf_d.hold_v = 1'b1;
            rf_d.hold   = bus_wdata[DATA_W-1:0];
        end
        if (sh_done)                     rf_d.rxd  = sh_rx;
        if (bus_wr && bus_addr == ADR_CTRL)
            rf_d.ctrl = bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
        if (bus_wr && bus_addr == ADR_SEL)
            rf_d.sel  = bus_wdata[NUM_TGT-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    spim_shifter #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .word    (rf_q.hold),
        .miso    (miso),
        .busy    (sh_busy),
        .sclk    (sclk),
        .mosi    (mosi),
        .done    (sh_done),
        .rx_word (sh_rx)
    );

    spim_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_done   (sh_done),
        .rx_read   (rd_rx),
        .stat_wr   (wr_stat),
        .tx_reject (tx_reject),
        .flags     (flags)
    );

    assign trdy = !rf_q.hold_v;
    assign tmt  = !rf_q.hold_v && !sh_busy;

    always_comb begin
        status         = '0;
        status[B_ROE]  = flags.roe;
        status[B_TOE]  = flags.toe;
        status[B_TMT]  = tmt;
        status[B_TRDY] = trdy;
        status[B_RRDY] = flags.rrdy;
        status[B_ERR]  = flags.roe | flags.toe;
    end

    always_comb begin
        case (bus_addr)
            ADR_RX:   bus_rdata = 32'(rf_q.rxd);
            ADR_STAT: bus_rdata = status;
            ADR_CTRL: bus_rdata = 32'(rf_q.ctrl);
            ADR_SEL:  bus_rdata = 32'(rf_q.sel);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq       = |(status[B_ERR:B_ROE] & rf_q.ctrl[B_ERR:B_ROE]);
    assign ss_active = !tmt || rf_q.ctrl[B_FORCE];
    assign ss_n      = ~(rf_q.sel & {NUM_TGT{ss_active}});

    // R4: an accepted word occupies the holding slot
    a_r4_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && trdy) |=> !trdy);
    // R9: no select while idle and not forced
    a_r9_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (tmt && !rf_q.ctrl[B_FORCE]) |-> (&ss_n));
    // R10: forced select reaches a line whenever a target is chosen
    a_r10_force_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_q.ctrl[B_FORCE] && (|rf_q.sel)) |-> !(&ss_n));
    // R2: a finished word lands in the receive register
    a_r2_rx_lands: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |=> (rf_q.rxd == $past(sh_rx)));

endmodule

// File: tb/spi_word_master_tb.sv
module spi_word_master_tb;
    localparam int DATA_W  = 8;
    localparam int NUM_TGT = 4;
    localparam int CLK_DIV = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2:0]         bus_addr = '0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               irq, sclk, mosi, miso;
    logic [NUM_TGT-1:0] ss_n;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_word_master #(.DATA_W(DATA_W), .NUM_TGT(NUM_TGT), .CLK_DIV(CLK_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    // scoreboard queues
    logic [DATA_W-1:0] mosi_q[$];
    logic [DATA_W-1:0] rx_q[$];
    logic [DATA_W-1:0] slv_q[$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // target model
    logic [DATA_W-1:0] slv_sr = '0;
    logic [DATA_W-1:0] cap = '0;
    bit slv_have = 0;
    int cap_bits = 0;
    int shf_bits = 0;
    assign miso = slv_sr[DATA_W-1];

    always @(negedge sclk) begin
        shf_bits++;
        if (shf_bits == DATA_W) begin
            shf_bits = 0;
            if (slv_q.size() > 0) slv_sr = slv_q.pop_front();
            else slv_have = 0;
        end else begin
            slv_sr = slv_sr << 1;
        end
    end

    // monitor: compare each word seen on mosi
    always @(posedge sclk) begin
        cap = {cap[DATA_W-2:0], mosi};
        cap_bits++;
        if (cap_bits == DATA_W) begin
            cap_bits = 0;
            if (mosi_q.size() == 0) chk("R2/R5 unexpected word on mosi", 32'(cap), 32'hFFFF_FFFF);
            else chk("R2 mosi word", 32'(cap), 32'(mosi_q.pop_front()));
        end
    end

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send(logic [DATA_W-1:0] tx, logic [DATA_W-1:0] slv);
        mosi_q.push_back(tx);
        rx_q.push_back(slv);
        if (!slv_have) begin slv_sr = slv; slv_have = 1; end
        else slv_q.push_back(slv);
        bus_write(3'd1, 32'(tx));
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        s = '0;
        while (s[5] !== 1'b1) bus_read(3'd2, s);
        @(negedge clk);
    endtask

    task automatic read_rx(string req);
        logic [31:0] d;
        bus_read(3'd0, d);
        chk(req, d, 32'(rx_q.pop_front()));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog R1-all act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        int hi;
        int falls;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(3'd2, d); chk("R1 status", d, 32'h060);
        bus_read(3'd0, d); chk("R1 rx data", d, 32'h0);
        chk("R1 ss_n", 32'(ss_n), 32'hF);
        chk("R1 sclk", 32'(sclk), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2/R9/R11 single word to target 2
        bus_write(3'd5, 32'h4);
        chk("R9 idle deselected", 32'(ss_n), 32'hF);
        send(8'hA5, 8'h3C);
        repeat (4) @(negedge clk);
        chk("R9 only target 2 low", 32'(ss_n), 32'hB);
        @(posedge sclk);
        hi = 0;
        @(negedge clk);
        while (sclk) begin hi++; @(negedge clk); end
        chk("R11 sclk high phase", 32'(hi), 32'(CLK_DIV));
        hi = 0;
        while (!sclk) begin hi++; @(negedge clk); end
        chk("R11 sclk low phase", 32'(hi), 32'(CLK_DIV));
        wait_idle();
        bus_read(3'd2, d); chk("R3 ready set", d, 32'h0E0);
        read_rx("R2 rx word");
        bus_read(3'd2, d); chk("R3 ready cleared by read", d, 32'h060);
        chk("R9 released", 32'(ss_n), 32'hF);

        // R8 interrupts and control readback
        bus_write(3'd3, 32'h7FF);
        bus_read(3'd3, d); chk("R8 control readback", d, 32'h5D8);
        bus_write(3'd3, 32'h080);
        chk("R8 irq off before data", 32'(irq), 32'h0);
        send(8'h81, 8'hC3);
        wait_idle();
        chk("R8 irq on data ready", 32'(irq), 32'h1);
        read_rx("R2 rx word 2");
        chk("R8 irq off after read", 32'(irq), 32'h0);
        bus_write(3'd3, 32'h040);
        chk("R8 irq on transmit ready", 32'(irq), 32'h1);
        bus_write(3'd3, 32'h0);

        // R4/R5/R6/R7 back-to-back, reject, overrun
        send(8'h5A, 8'h11);
        @(negedge clk);
        send(8'h0F, 8'hE7);
        bus_read(3'd2, d); chk("R4 slot full and busy", d, 32'h000);
        bus_write(3'd1, 32'h99);
        bus_read(3'd2, d); chk("R5 transmit overrun with R7 summary", d, 32'h110);
        wait_idle();
        bus_read(3'd2, d); chk("R6 receive overrun", d, 32'h1F8);
        bus_write(3'd3, 32'h100);
        chk("R8 irq on error", 32'(irq), 32'h1);
        bus_write(3'd3, 32'h0);
        void'(rx_q.pop_front());
        read_rx("R6 overwritten data");
        bus_write(3'd2, 32'h0);
        bus_read(3'd2, d); chk("R7 errors cleared", d, 32'h060);

        // R6 read in the completion cycle
        send(8'h3E, 8'h42);
        wait_idle();
        mosi_q.push_back(8'hC1);
        rx_q.push_back(8'h9D);
        slv_sr = 8'h9D; slv_have = 1;
        bus_write(3'd1, 32'hC1);
        falls = 0;
        prev = sclk;
        while (falls < DATA_W) begin
            @(negedge clk);
            if (prev && !sclk) falls++;
            prev = sclk;
        end
        bus_addr = 3'd0; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R6 same-cycle read returns old word", d, 32'(rx_q.pop_front()));
        bus_read(3'd2, d); chk("R6 no overrun on same-cycle read", d, 32'h0E0);
        read_rx("R6 new word after collision");

        // R10 forced select
        bus_write(3'd5, 32'h2);
        bus_write(3'd3, 32'h400);
        chk("R10 forced low while idle", 32'(ss_n), 32'hD);
        send(8'h77, 8'h18);
        wait_idle();
        chk("R10 still low after word", 32'(ss_n), 32'hD);
        read_rx("R2 rx under force");
        bus_write(3'd5, 32'h0);
        chk("R9 zero select keeps all high", 32'(ss_n), 32'hF);
        bus_write(3'd5, 32'h2);
        bus_write(3'd3, 32'h0);
        chk("R10 released on clear", 32'(ss_n), 32'hF);

        repeat (4) @(negedge clk);
        chk("R2 all words observed", 32'(mosi_q.size()), 32'h0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule